// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the address that drives a 128-word control store in a microprogrammed controller. A 7-bit control address register holds the current address. On every rising clock edge it takes one of four values: the current address plus one, a target address carried in the microinstruction, a routine entry point derived from the instruction opcode, or an address saved by an earlier subroutine call.

Each cycle the current microinstruction supplies three fields. A 3-bit field picks one of eight condition inputs. A 2-bit field picks the address source. A 7-bit field carries the target address. Condition input 0 is replaced inside the block by a constant 1, so that selecting it makes any conditional transfer unconditional. Opcode dispatch needs no condition. It places every opcode routine in a four-word slot in the lower half of the store.

Top module: `mseq_addr_sequencer`

## Requirements
- R1: While `rst_i` is high at a rising edge, `car_o` becomes FETCH_ADDR (default 0) and the saved return address is cleared to 0. A taken return right after reset therefore goes to address 0.
- R2: With `src_sel_i`=0 (jump mode) and the selected condition true, `car_o` takes `brch_addr_i` at the next edge.
- R3: In jump, call or return mode with the selected condition false, `car_o` becomes `car_o`+1 at the next edge.
- R4: The condition is `status_i[cond_sel_i]` for selects 1 to 7. Select 0 always reads as true, and `status_i[0]` has no effect on the next address or on `taken_o`.
- R5: Incrementing from address 127 gives address 0.
- R6: With `src_sel_i`=3 (dispatch mode), `car_o` becomes {1'b0, `opcode_i`, 2'b00} at the next edge, whatever the condition inputs.
- R7: With `src_sel_i`=1 (call mode) and the condition true, the return address becomes `car_o`+1 (mod 128) and `car_o` takes `brch_addr_i`.
- R8: A call whose condition is false leaves the saved return address unchanged.
- R9: With `src_sel_i`=2 (return mode) and the condition true, `car_o` takes the saved return address.
- R10: `taken_o` is combinational. It is 1 in dispatch mode, or in the other modes when the selected condition is true, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| brch_addr_i | input | 7 | Target address field of the microinstruction |
| cond_sel_i | input | 3 | Condition select (0 = constant true) |
| src_sel_i | input | 2 | Address source: 0 jump, 1 call, 2 return, 3 dispatch |
| status_i | input | 8 | Condition inputs (bit 0 unused) |
| opcode_i | input | 4 | Instruction opcode for dispatch |
| car_o | output | 7 | Control address register |
| taken_o | output | 1 | Non-sequential next address selected |

## Verification
The hardest state to reach is the saved return address, because no port shows it. It only appears when a taken return loads it into `car_o`. The stimulus therefore places calls before returns: first a taken call, then a call with a false condition that must not overwrite the saved value, then a taken return. It also makes a call from address 127 so that the saved value wraps to 0. A sweep over every condition select, with both walking-one and walking-zero status patterns, exercises the constant input and confirms that `status_i[0]` is ignored.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int CAR_W   = 7;
    localparam int OPC_W   = 4;
    localparam int SEL_W   = 3;
    localparam int NSTAT   = 1 << SEL_W;
    localparam int SLOT_W  = 2;
    localparam int PAD_W   = CAR_W - OPC_W - SLOT_W;
    localparam int ONE_IDX = 0;

    typedef logic [CAR_W-1:0] car_t;
    typedef logic [OPC_W-1:0] opc_t;
    typedef logic [SEL_W-1:0] csel_t;

    typedef enum logic [1:0] {
        SRC_JUMP     = 2'd0,
        SRC_CALL     = 2'd1,
        SRC_RETURN   = 2'd2,
        SRC_DISPATCH = 2'd3
    } src_mode_e;

    typedef struct packed {
        car_t next_car;
        logic ret_wr;
        car_t ret_data;
        logic taken;
    } seq_dec_t;

    function automatic car_t dispatch_addr(input opc_t opc);
        return {{PAD_W{1'b0}}, opc, {SLOT_W{1'b0}}};
    endfunction

    function automatic car_t car_inc(input car_t a);
        return a + car_t'(1);
    endfunction

endpackage

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux
    import mseq_pkg::*;
(
    input  logic [NSTAT-1:0] status_i,
    input  csel_t            sel_i,
    output logic             cond_o
);
    logic [NSTAT-1:0] cond_vec;

    for (genvar g = 0; g < NSTAT; g++) begin : g_in
        if (g == ONE_IDX) begin : g_const
            assign cond_vec[g] = 1'b1;
        end else begin : g_stat
            assign cond_vec[g] = status_i[g];
        end
    end

    assign cond_o = cond_vec[sel_i];
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
    import mseq_pkg::*;
(
    input  car_t       car_i,
    input  car_t       ret_i,
    input  car_t       brch_i,
    input  opc_t       opc_i,
    input  src_mode_e  mode_i,
    input  logic       cond_i,
    output seq_dec_t   dec_o
);
    car_t inc;
    assign inc = car_inc(car_i);

    always_comb begin
        dec_o.next_car = inc;
        dec_o.ret_wr   = 1'b0;
        dec_o.ret_data = inc;
        dec_o.taken    = 1'b0;
        unique case (mode_i)
            SRC_JUMP: begin
                if (cond_i) begin
                    dec_o.next_car = brch_i;
                    dec_o.taken    = 1'b1;
                end
            end
            SRC_CALL: begin
                if (cond_i) begin
                    dec_o.next_car = brch_i;
                    dec_o.ret_wr   = 1'b1;
                    dec_o.taken    = 1'b1;
                end
            end
            SRC_RETURN: begin
                if (cond_i) begin
                    dec_o.next_car = ret_i;
                    dec_o.taken    = 1'b1;
                end
            end
            SRC_DISPATCH: begin
                dec_o.next_car = dispatch_addr(opc_i);
                dec_o.taken    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mseq_ret_reg.sv
module mseq_ret_reg
    import mseq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic wr_i,
    input  car_t d_i,
    output car_t q_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)     q_o <= '0;
        else if (wr_i) q_o <= d_i;
    end
endmodule

// File: rtl/mseq_addr_sequencer.sv
module mseq_addr_sequencer
    import mseq_pkg::*;
#(
    parameter logic [6:0] FETCH_ADDR = 7'd0
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [6:0] brch_addr_i,
    input  logic [2:0] cond_sel_i,
    input  logic [1:0] src_sel_i,
    input  logic [7:0] status_i,
    input  logic [3:0] opcode_i,
    output logic [6:0] car_o,
    output logic       taken_o
);
    car_t     car_q;
    car_t     ret_q;
    logic     cond;
    seq_dec_t dec;

    mseq_cond_mux u_cmux (
        .status_i (status_i),
        .sel_i    (cond_sel_i),
        .cond_o   (cond)
    );

    mseq_next_addr u_nxt (
        .car_i  (car_q),
        .ret_i  (ret_q),
        .brch_i (brch_addr_i),
        .opc_i  (opcode_i),
        .mode_i (src_mode_e'(src_sel_i)),
        .cond_i (cond),
        .dec_o  (dec)
    );

    mseq_ret_reg u_ret (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .wr_i  (dec.ret_wr),
        .d_i   (dec.ret_data),
        .q_o   (ret_q)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) car_q <= FETCH_ADDR;
        else       car_q <= dec.next_car;
    end

    assign car_o   = car_q;
    assign taken_o = dec.taken;
endmodule

// File: rtl/mseq_addr_sequencer_chk.sv
module mseq_addr_sequencer_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [6:0] brch_addr_i,
    input logic [2:0] cond_sel_i,
    input logic [1:0] src_sel_i,
    input logic [7:0] status_i,
    input logic [3:0] opcode_i,
    input logic [6:0] car_o,
    input logic       taken_o
);
    logic sel_true;
    assign sel_true = (cond_sel_i == 3'd0) || status_i[cond_sel_i];

    // R2
    jump_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_sel_i == 2'd0 && sel_true) |=> car_o == $past(brch_addr_i));

    // R3
    seq_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_sel_i != 2'd3 && !sel_true) |=> car_o == 7'($past(car_o) + 7'd1));

    // R5
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (car_o == 7'd127 && src_sel_i != 2'd3 && !sel_true) |=> car_o == 7'd0);

    // R6
    dispatch_slot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_sel_i == 2'd3) |=> car_o == {1'b0, $past(opcode_i), 2'b00});

    // R10
    taken_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        taken_o == (src_sel_i == 2'd3 || sel_true));

    // R7
    call_target_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (src_sel_i == 2'd1 && sel_true) |=> car_o == $past(brch_addr_i));
endmodule

bind mseq_addr_sequencer mseq_addr_sequencer_chk chk_i (.*);

// File: tb/mseq_addr_sequencer_tb_top.sv
module mseq_addr_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] brch;
    logic [2:0] csel;
    logic [1:0] src;
    logic [7:0] stat;
    logic [3:0] opc;
    logic [6:0] car;
    logic       taken;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [6:0] car;
        string      tag;
    } exp_t;
    exp_t q[$];

    logic [6:0] m_car;
    logic [6:0] m_ret;

    always #2 clk = ~clk;

    mseq_addr_sequencer dut_i (
        .clk_i(clk), .rst_i(rst), .brch_addr_i(brch), .cond_sel_i(csel),
        .src_sel_i(src), .status_i(stat), .opcode_i(opc),
        .car_o(car), .taken_o(taken)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: applies one microinstruction and queues the expected address
    task automatic step(input logic [1:0] s, input logic [2:0] cs,
                        input logic [7:0] st, input logic [6:0] b,
                        input logic [3:0] o, input string tag);
        bit   c;
        bit   exp_tk;
        logic [6:0] nxt;
        @(negedge clk);
        src = s; csel = cs; stat = st; brch = b; opc = o;
        c = (cs == 3'd0) ? 1'b1 : st[cs];
        exp_tk = (s == 2'd3) || c;
        nxt = m_car + 7'd1;
        case (s)
            2'd0: if (c) nxt = b;
            2'd1: if (c) begin m_ret = m_car + 7'd1; nxt = b; end
            2'd2: if (c) nxt = m_ret;
            default: nxt = {1'b0, o, 2'b00};
        endcase
        #1;
        check(taken === exp_tk, {"R10 taken ", tag}, int'(taken), int'(exp_tk));
        m_car = nxt;
        q.push_back('{nxt, tag});
    endtask

    // monitor: compares the register after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(car === e.car, e.tag, int'(car), int'(e.car));
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        done = 1;
    end

    initial begin
        rst = 1; brch = '0; csel = '0; src = '0; stat = '0; opc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(car === 7'd0, "R1 reset car", int'(car), 0);
        rst = 0;
        m_car = 7'd0; m_ret = 7'd0;
        // R1 return register cleared: taken return goes to 0
        step(2'd2, 3'd0, 8'h00, 7'd99, 4'd0, "R1 R9 return after reset");
        // R4 select 0 always true, status[0] ignored
        step(2'd0, 3'd0, 8'h00, 7'h50, 4'd0, "R4 const-one jump");
        step(2'd0, 3'd3, 8'h08, 7'h21, 4'd0, "R2 jump taken");
        step(2'd0, 3'd3, 8'hF7, 7'h70, 4'd0, "R3 jump not taken");
        step(2'd0, 3'd7, 8'h80, 7'd127, 4'd0, "R2 jump to 127");
        step(2'd0, 3'd7, 8'h7F, 7'h11, 4'd0, "R5 wrap");
        step(2'd3, 3'd5, 8'h00, 7'h11, 4'hA, "R6 dispatch A");
        step(2'd3, 3'd1, 8'hFF, 7'h11, 4'hF, "R6 dispatch F");
        step(2'd1, 3'd2, 8'h04, 7'h10, 4'd0, "R7 call taken");
        step(2'd0, 3'd4, 8'h00, 7'h30, 4'd0, "R3 inc in sub");
        step(2'd1, 3'd6, 8'hBF, 7'h44, 4'd0, "R8 call not taken");
        step(2'd2, 3'd1, 8'hFD, 7'h00, 4'd0, "R3 return not taken");
        step(2'd2, 3'd1, 8'h02, 7'h00, 4'd0, "R9 return to 0x3D");
        step(2'd0, 3'd0, 8'h00, 7'd127, 4'd0, "R2 to 127");
        step(2'd1, 3'd0, 8'h00, 7'h05, 4'd0, "R7 call from 127");
        step(2'd2, 3'd0, 8'h00, 7'h66, 4'd0, "R9 R5 return wraps to 0");
        // sweep of selects with walking-one and walking-zero patterns (R4)
        for (int p = 0; p < 8; p++) begin
            for (int k = 0; k < 8; k++) begin
                step(2'd0, 3'(k), 8'(1 << p), 7'(p * 8 + k), 4'd0, "R4 sweep one");
                step(2'd0, 3'(k), ~8'(1 << p), 7'(100 - k), 4'd0, "R4 sweep zero");
            end
        end
        for (int o = 0; o < 16; o++) step(2'd3, 3'd0, 8'h00, 7'd0, 4'(o), "R6 dispatch sweep");
        @(negedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        wait (done);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule